// File: doc/BRIEF.md
# Fuse programming power sequencer

This block runs one fuse-programming session from start to finish. When software or a test controller asks for a session, the block waits until every core supply reports power-good. It then turns on the high-voltage fuse supply and waits for that supply's comparator to read above its threshold. After a fixed settling dwell it grants the JTAG side permission to issue fuse instructions. When the JTAG side reports that it is finished, the block removes the grant and holds the supply for a second dwell. It then turns the supply off and waits for the comparator to show that the supply has fallen below a quarter of nominal. Only then does it release the other supplies so that they may power down.

While the grant is active, the SPI bus and the external configuration clock must stay quiet. Any core supply that drops out while the fuse supply is on is treated as a fault. In either case the grant and the supply enable are removed on the next cycle, and the block stays in an error state until reset. The dwell lengths are given in milliseconds and converted to cycles from a clock-frequency parameter.

Top module: `fuse_pwr_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, every output is low.
- R2: `hv_supply_en` rises only on the cycle after a cycle in which the request was being serviced and every bit of `rails_good` was 1. While any rail is low, the block keeps waiting with the enable off.
- R3: Once the comparator reads high, `fuse_grant` rises after `SETTLE` + 1 further cycles, where a dwell in cycles is `(CLK_HZ/1000)*ms` with a floor of 1. This makes the gap from the supply enable to the grant at least `SETTLE` cycles.
- R4: A `jtag_done` pulse seen during the grant removes the grant on the next cycle. `hv_supply_en` then stays high for exactly `HOLD` + 1 cycles before it falls.
- R5: After the supply is off, `rails_release` and `session_done` rise only once the comparator reads low. `rails_release` is never high while the comparator reads high.
- R6: If `spi_active` or `cfg_clk_active` is high in a grant cycle, the next cycle has `fuse_grant` and `hv_supply_en` low and `session_error` high.
- R7: If any `rails_good` bit is low in a cycle in which the supply is enabled, the next cycle has the enable low and `session_error` high.
- R8: `session_error` stays high, whatever the request does, until reset. In error, `rails_release` follows the inverted comparator.
- R9: `cfg_inhibit` is high in every state except idle and done. This includes every cycle with the grant or the supply enable active.
- R10: From done, dropping `prog_req` returns the block to idle, with all outputs low, on the next cycle. A new session can then start.
- R11: Interface activity outside the grant window, for example while waiting for the rails or during the post-program hold, has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rails_good | input | N_RAILS | Power-good flag from each core supply |
| hv_above_q | input | 1 | Fuse supply comparator: high while above a quarter of nominal |
| prog_req | input | 1 | Request for a programming session, held for its length |
| jtag_done | input | 1 | JTAG side reports that fuse programming has finished |
| spi_active | input | 1 | SPI bus activity flag |
| cfg_clk_active | input | 1 | External configuration clock activity flag |
| hv_supply_en | output | 1 | Enable for the fuse supply regulator |
| fuse_grant | output | 1 | Lets JTAG fuse instructions through |
| rails_release | output | 1 | Other supplies may now power down |
| cfg_inhibit | output | 1 | Blocks the start of device configuration |
| session_done | output | 1 | Session finished normally |
| session_error | output | 1 | Session aborted; held until reset |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that the comparator follows the supply enable with some ramp delay, rising after the enable goes on and falling some cycles after it goes off. The bench respects this with a behavioural model of the supply: a level that climbs or decays by one step per clock while the enable is on or off, with an option to stall the decay. All bench inputs are changed one nanosecond after a rising edge, so the design and the reference model see the same stable values at each edge.

// File: rtl/fps_pkg.sv
`timescale 1ns/1ps
package fps_pkg;

    typedef enum logic [3:0] {
        S_IDLE       = 4'd0,
        S_WAIT_RAILS = 4'd1,
        S_HV_RAMP    = 4'd2,
        S_SETTLE     = 4'd3,
        S_PROGRAM    = 4'd4,
        S_HOLD       = 4'd5,
        S_HV_OFF     = 4'd6,
        S_DISCHARGE  = 4'd7,
        S_DONE       = 4'd8,
        S_ERROR      = 4'd9
    } fps_state_e;

    // Conditions observed at the block edge, already reduced
    typedef struct packed {
        logic req;
        logic rails_ok;
        logic hv_high;
        logic jtag_done;
        logic bus_busy;
    } fps_cond_t;

    // Control outputs of the sequencer
    typedef struct packed {
        logic hv_en;
        logic grant;
        logic release_ok;
        logic inhibit;
        logic done;
        logic err;
    } fps_ctrl_t;

    // Millisecond dwell to clock cycles, never below one
    function automatic int unsigned ms_to_cycles(int unsigned hz, int unsigned ms);
        int unsigned c;
        c = (hz / 1000) * ms;
        return (c == 0) ? 1 : c;
    endfunction

    // True in every state that keeps the fuse supply switched on
    function automatic logic supply_on(fps_state_e s);
        return (s == S_HV_RAMP) || (s == S_SETTLE) ||
               (s == S_PROGRAM) || (s == S_HOLD);
    endfunction

    function automatic fps_ctrl_t decode_state(fps_state_e s, logic hv_high);
        fps_ctrl_t c;
        c.hv_en      = supply_on(s);
        c.grant      = (s == S_PROGRAM);
        c.release_ok = ((s == S_DONE) || (s == S_ERROR)) && !hv_high;
        c.inhibit    = (s != S_IDLE) && (s != S_DONE);
        c.done       = (s == S_DONE);
        c.err        = (s == S_ERROR);
        return c;
    endfunction

endpackage

// File: rtl/fps_cond_mon.sv
`timescale 1ns/1ps
module fps_cond_mon
    import fps_pkg::*;
#(
    parameter int unsigned N_RAILS       = 3,
    parameter bit          WATCH_CFG_CLK = 1'b1
) (
    input  logic [N_RAILS-1:0] rails_good,
    input  logic               hv_above_q,
    input  logic               prog_req,
    input  logic               jtag_done,
    input  logic               spi_active,
    input  logic               cfg_clk_active,
    output fps_cond_t          cond
);

    logic busy;

    generate
        if (WATCH_CFG_CLK) begin : g_both
            assign busy = spi_active | cfg_clk_active;
        end else begin : g_spi_only
            logic unused_clk;
            assign unused_clk = cfg_clk_active;
            assign busy = spi_active;
        end
    endgenerate

    always_comb begin
        cond.req       = prog_req;
        cond.rails_ok  = &rails_good;
        cond.hv_high   = hv_above_q;
        cond.jtag_done = jtag_done;
        cond.bus_busy  = busy;
    end

endmodule

// File: rtl/fps_dwell_timer.sv
`timescale 1ns/1ps
module fps_dwell_timer #(
    parameter int unsigned LIMIT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);

    localparam int unsigned W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == TOP);

    // R3/R4: expiry needs the run request to have been present before
    p_expiry_follows_run_r3 : assert property (@(posedge clk) disable iff (rst)
        expired |-> $past(run));

endmodule

// File: rtl/fps_seq_fsm.sv
`timescale 1ns/1ps
module fps_seq_fsm
    import fps_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 10,
    parameter int unsigned HOLD_CYC   = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  fps_cond_t  cond,
    input  logic       settle_done,
    input  logic       hold_done,
    output fps_state_e state_q,
    output fps_ctrl_t  ctrl
);

    fps_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (cond.req) state_d = S_WAIT_RAILS;
            S_WAIT_RAILS: if (cond.rails_ok) state_d = S_HV_RAMP;
            S_HV_RAMP: begin
                if (!cond.rails_ok)    state_d = S_ERROR;
                else if (cond.hv_high) state_d = S_SETTLE;
            end
            S_SETTLE: begin
                if (!cond.rails_ok)   state_d = S_ERROR;
                else if (settle_done) state_d = S_PROGRAM;
            end
            S_PROGRAM: begin
                if (!cond.rails_ok || cond.bus_busy) state_d = S_ERROR;
                else if (cond.jtag_done)             state_d = S_HOLD;
            end
            S_HOLD: begin
                if (!cond.rails_ok) state_d = S_ERROR;
                else if (hold_done) state_d = S_HV_OFF;
            end
            S_HV_OFF:     state_d = S_DISCHARGE;
            S_DISCHARGE:  if (!cond.hv_high) state_d = S_DONE;
            S_DONE:       if (!cond.req) state_d = S_IDLE;
            S_ERROR:      state_d = S_ERROR;
            default:      state_d = S_ERROR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    assign ctrl = decode_state(state_q, cond.hv_high);

    // Observation counters for the dwell properties
    logic [31:0] hv_on_cnt;
    logic [31:0] post_grant_cnt;

    always_ff @(posedge clk) begin
        if (rst || !ctrl.hv_en)            hv_on_cnt <= '0;
        else if (hv_on_cnt != 32'hFFFF_FFFF) hv_on_cnt <= hv_on_cnt + 1;
        if (rst || ctrl.grant)                  post_grant_cnt <= '0;
        else if (post_grant_cnt != 32'hFFFF_FFFF) post_grant_cnt <= post_grant_cnt + 1;
    end

    p_supply_after_rails_r2 : assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.hv_en) |-> $past(cond.rails_ok));

    p_grant_after_settle_r3 : assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.grant) |-> (hv_on_cnt > SETTLE_CYC));

    p_hold_before_drop_r4 : assert property (@(posedge clk) disable iff (rst)
        ($fell(ctrl.hv_en) && !ctrl.err) |-> (post_grant_cnt > HOLD_CYC));

    p_release_when_low_r5 : assert property (@(posedge clk) disable iff (rst)
        ctrl.release_ok |-> (!cond.hv_high && !ctrl.hv_en));

    p_bus_interlock_r6 : assert property (@(posedge clk) disable iff (rst)
        (ctrl.grant && cond.bus_busy) |=> (!ctrl.grant && !ctrl.hv_en && ctrl.err));

    p_rail_loss_r7 : assert property (@(posedge clk) disable iff (rst)
        (ctrl.hv_en && !cond.rails_ok) |=> (!ctrl.hv_en && ctrl.err));

    p_error_sticky_r8 : assert property (@(posedge clk) disable iff (rst)
        ctrl.err |=> ctrl.err);

endmodule

// File: rtl/fuse_pwr_seq.sv
`timescale 1ns/1ps
module fuse_pwr_seq
    import fps_pkg::*;
#(
    parameter int unsigned N_RAILS   = 3,
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned SETTLE_MS = 10,
    parameter int unsigned HOLD_MS   = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_RAILS-1:0] rails_good,
    input  logic               hv_above_q,
    input  logic               prog_req,
    input  logic               jtag_done,
    input  logic               spi_active,
    input  logic               cfg_clk_active,
    output logic               hv_supply_en,
    output logic               fuse_grant,
    output logic               rails_release,
    output logic               cfg_inhibit,
    output logic               session_done,
    output logic               session_error
);

    localparam int unsigned SETTLE_CYC = ms_to_cycles(CLK_HZ, SETTLE_MS);
    localparam int unsigned HOLD_CYC   = ms_to_cycles(CLK_HZ, HOLD_MS);

    fps_cond_t  cond;
    fps_ctrl_t  ctrl;
    fps_state_e state;
    logic       settle_done;
    logic       hold_done;

    fps_cond_mon #(
        .N_RAILS       (N_RAILS),
        .WATCH_CFG_CLK (1'b1)
    ) u_cond (
        .rails_good     (rails_good),
        .hv_above_q     (hv_above_q),
        .prog_req       (prog_req),
        .jtag_done      (jtag_done),
        .spi_active     (spi_active),
        .cfg_clk_active (cfg_clk_active),
        .cond           (cond)
    );

    fps_dwell_timer #(.LIMIT(SETTLE_CYC)) u_settle_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (state == S_SETTLE),
        .expired (settle_done)
    );

    fps_dwell_timer #(.LIMIT(HOLD_CYC)) u_hold_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (state == S_HOLD),
        .expired (hold_done)
    );

    fps_seq_fsm #(
        .SETTLE_CYC (SETTLE_CYC),
        .HOLD_CYC   (HOLD_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cond        (cond),
        .settle_done (settle_done),
        .hold_done   (hold_done),
        .state_q     (state),
        .ctrl        (ctrl)
    );

    assign hv_supply_en  = ctrl.hv_en;
    assign fuse_grant    = ctrl.grant;
    assign rails_release = ctrl.release_ok;
    assign cfg_inhibit   = ctrl.inhibit;
    assign session_done  = ctrl.done;
    assign session_error = ctrl.err;

    // R9: configuration stays blocked while the supply or grant is live
    p_inhibit_covers_grant_r9 : assert property (@(posedge clk) disable iff (rst)
        (fuse_grant || hv_supply_en) |-> cfg_inhibit);

endmodule

// File: tb/fuse_pwr_seq_test.sv
`timescale 1ns/1ps
module fuse_pwr_seq_test;

    localparam int N_RAILS  = 3;
    localparam int TB_HZ    = 2000;
    localparam int SETTLE_N = (TB_HZ / 1000) * 10;   // 20 cycles
    localparam int HOLD_N   = (TB_HZ / 1000) * 5;    // 10 cycles
    localparam int RAMP_TOP = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [N_RAILS-1:0] rails_good = '0;
    logic               hv_above_q = 1'b0;
    logic               prog_req = 1'b0;
    logic               jtag_done = 1'b0;
    logic               spi_active = 1'b0;
    logic               cfg_clk_active = 1'b0;
    logic hv_supply_en, fuse_grant, rails_release, cfg_inhibit, session_done, session_error;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    bit stuck = 1'b0;
    int lvl = 0;

    always #2.5 clk = ~clk;

    fuse_pwr_seq #(
        .N_RAILS(N_RAILS), .CLK_HZ(TB_HZ), .SETTLE_MS(10), .HOLD_MS(5)
    ) uut (
        .clk(clk), .rst(rst), .rails_good(rails_good), .hv_above_q(hv_above_q),
        .prog_req(prog_req), .jtag_done(jtag_done), .spi_active(spi_active),
        .cfg_clk_active(cfg_clk_active), .hv_supply_en(hv_supply_en),
        .fuse_grant(fuse_grant), .rails_release(rails_release),
        .cfg_inhibit(cfg_inhibit), .session_done(session_done),
        .session_error(session_error)
    );

    // Fuse supply model: level climbs while enabled, decays otherwise
    always @(posedge clk) begin
        #1;
        if (hv_supply_en) begin
            if (lvl < RAMP_TOP) lvl++;
        end else if (!stuck && lvl > 0) begin
            lvl--;
        end
        hv_above_q = (lvl * 4 > RAMP_TOP);
    end

    // Behavioural reference: phase numbers and a wait counter
    localparam int M_IDLE = 0, M_RAILS = 1, M_UP = 2, M_SET = 3, M_PROG = 4,
                   M_HOLD = 5, M_OFF = 6, M_DIS = 7, M_DONE = 8, M_ERR = 9;
    int ph = M_IDLE;
    int w  = 0;
    bit started = 1'b0;

    always @(posedge clk) begin : mdl
        bit ok;
        bit busy;
        ok = &rails_good;
        busy = spi_active || cfg_clk_active;
        started = 1'b1;
        if (rst) begin
            ph = M_IDLE; w = 0;
        end else begin
            case (ph)
                M_IDLE:  if (prog_req) ph = M_RAILS;
                M_RAILS: if (ok) ph = M_UP;
                M_UP:    if (!ok) ph = M_ERR; else if (hv_above_q) begin ph = M_SET; w = 0; end
                M_SET:   if (!ok) ph = M_ERR; else if (w == SETTLE_N) ph = M_PROG; else w++;
                M_PROG:  if (!ok || busy) ph = M_ERR; else if (jtag_done) begin ph = M_HOLD; w = 0; end
                M_HOLD:  if (!ok) ph = M_ERR; else if (w == HOLD_N) ph = M_OFF; else w++;
                M_OFF:   ph = M_DIS;
                M_DIS:   if (!hv_above_q) ph = M_DONE;
                M_DONE:  if (!prog_req) ph = M_IDLE;
                default: ph = M_ERR;
            endcase
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Lockstep comparison every cycle, away from the rising edge
    always @(negedge clk) begin
        int e_hv, e_gr, e_rel, e_inh, e_done, e_err;
        if (started && !finished) begin
            e_hv   = (ph == M_UP || ph == M_SET || ph == M_PROG || ph == M_HOLD);
            e_gr   = (ph == M_PROG);
            e_rel  = (ph == M_DONE || ph == M_ERR) && !hv_above_q;
            e_inh  = (ph != M_IDLE && ph != M_DONE);
            e_done = (ph == M_DONE);
            e_err  = (ph == M_ERR);
            check(hv_supply_en == e_hv, "R2", "hv_supply_en", hv_supply_en, e_hv);
            check(fuse_grant == e_gr, "R3", "fuse_grant", fuse_grant, e_gr);
            check(rails_release == e_rel, "R5", "rails_release", rails_release, e_rel);
            check(cfg_inhibit == e_inh, "R9", "cfg_inhibit", cfg_inhibit, e_inh);
            check(session_done == e_done, "R10", "session_done", session_done, e_done);
            check(session_error == e_err, "R8", "session_error", session_error, e_err);
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wait_grant();
        for (int i = 0; i < 400 && !fuse_grant; i++) @(negedge clk);
    endtask

    task automatic wait_hv();
        for (int i = 0; i < 400 && !hv_supply_en; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(2); rst = 1'b0;
    endtask

    initial begin
        int n;
        bit gr_first;
        // R1: reset state
        tick(3);
        @(negedge clk);
        check({hv_supply_en, fuse_grant, rails_release, cfg_inhibit, session_done, session_error} == 6'b0,
              "R1", "outputs in reset", 0, 0);
        tick(1); rst = 1'b0;
        @(negedge clk);
        check({hv_supply_en, fuse_grant, cfg_inhibit, session_done, session_error} == 5'b0,
              "R1", "outputs after reset", 0, 0);

        // R2 and R11: rails incomplete, bus active while waiting
        tick(1);
        rails_good = 3'b011; prog_req = 1'b1; spi_active = 1'b1;
        tick(10);
        @(negedge clk);
        check(hv_supply_en == 1'b0, "R2", "enable while a rail is low", hv_supply_en, 0);
        check(cfg_inhibit == 1'b1, "R9", "inhibit while waiting", cfg_inhibit, 1);
        check(session_error == 1'b0, "R11", "error from early bus activity", session_error, 0);
        tick(1);
        spi_active = 1'b0; rails_good = 3'b111;

        // R3: gap from enable to grant
        wait_hv();
        n = 0;
        for (int i = 0; i < 400 && !fuse_grant; i++) begin
            if (hv_supply_en) n++;
            @(negedge clk);
        end
        check(n >= SETTLE_N + 1, "R3", "enable-to-grant cycles", n, SETTLE_N + 1);
        tick(3);
        @(negedge clk);
        check(cfg_inhibit && fuse_grant, "R9", "inhibit during grant", cfg_inhibit, 1);

        // R4 and R11: hold dwell with clock activity during the hold
        tick(1);
        jtag_done = 1'b1;
        tick(1);
        jtag_done = 1'b0; cfg_clk_active = 1'b1; stuck = 1'b1;
        n = 0; gr_first = 1'b1;
        @(negedge clk);
        gr_first = fuse_grant;
        for (int i = 0; i < 400 && hv_supply_en; i++) begin
            n++;
            @(negedge clk);
        end
        check(gr_first == 1'b0, "R4", "grant after done", gr_first, 0);
        check(n == HOLD_N + 1, "R4", "hold cycles", n, HOLD_N + 1);

        // R5: release waits for the comparator to fall
        tick(8);
        @(negedge clk);
        check(rails_release == 1'b0 && session_done == 1'b0, "R5", "release while supply high",
              rails_release, 0);
        tick(1);
        stuck = 1'b0; cfg_clk_active = 1'b0;
        for (int i = 0; i < 60 && !session_done; i++) @(negedge clk);
        check(session_done && rails_release, "R5", "release after discharge", rails_release, 1);
        check(session_error == 1'b0, "R11", "error from hold activity", session_error, 0);

        // R10: done back to idle
        tick(1);
        prog_req = 1'b0;
        tick(1);
        @(negedge clk);
        check(!session_done && !cfg_inhibit, "R10", "idle after request drop", session_done, 0);

        // R6: SPI activity in the grant window
        tick(1);
        prog_req = 1'b1;
        wait_grant();
        tick(1);
        spi_active = 1'b1;
        tick(1);
        spi_active = 1'b0;
        @(negedge clk);
        check(session_error && !fuse_grant && !hv_supply_en, "R6", "abort on SPI activity",
              session_error, 1);

        // R8: error stays regardless of request
        tick(1);
        prog_req = 1'b0; tick(5); prog_req = 1'b1; tick(3);
        @(negedge clk);
        check(session_error && !hv_supply_en, "R8", "error held", session_error, 1);
        for (int i = 0; i < 60 && !rails_release; i++) @(negedge clk);
        check(rails_release == 1'b1, "R8", "release in error once low", rails_release, 1);
        tick(1);
        do_reset();
        @(negedge clk);
        check(session_error == 1'b0, "R8", "error cleared by reset", session_error, 0);

        // R7: rail loss while supply on
        wait_hv();
        tick(3);
        rails_good = 3'b101;
        tick(1);
        @(negedge clk);
        check(session_error && !hv_supply_en, "R7", "abort on rail loss", session_error, 1);
        tick(1);
        rails_good = 3'b111;
        tick(10);
        do_reset();

        // R6: configuration clock activity in the grant window
        wait_grant();
        tick(1);
        cfg_clk_active = 1'b1;
        tick(1);
        cfg_clk_active = 1'b0;
        @(negedge clk);
        check(session_error && !fuse_grant, "R6", "abort on config clock", session_error, 1);
        tick(2);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule